// File: doc/BRIEF.md
# Programmable System Clock Divider

This block derives two clock-enable streams, a processor enable and a master enable, from one of four source enables. All of it runs on one fast system clock. A single configuration register holds three fields. The first picks the source. The second sets a prescaler on the selected source, which forms the processor enable. The third sets a further divider on the processor enable, which forms the master enable.

Software changes the register one field at a time. A write that touches more than one field is thrown away and raises a sticky error flag. A write that names an undefined divider code is also thrown away. Writes are ignored while the write-protect input is high.

After an accepted change the ready flag drops. The new setting takes effect at the end of the current master period, so no period is cut short. Ready rises again after a short fixed settling count. Software waits for ready before it changes the next field.

Top module: `sysclk_div_ctrl`

## Requirements
- R1: After reset, `cfg_rd_o` reads 0x00000001 (source 1, prescaler code 0, divider code 0), `ready_o` is 1 and `err_o` is 0.
- R2: The prescaler field is at bits [6:4]. Its codes give these ratios: 0→1, 1→2, 2→4, 3→8, 4→16, 5→32, 6→64, 7→3. `pck_en_o` is high for one cycle in each run of that many selected-source ticks, and only in a cycle where the selected source enable is high.
- R3: The divider field is at bits [10:8]. Its codes give these ratios: 0→1, 1→2, 2→4, 3→3, 4→5. `mck_en_o` is high on one `pck_en_o` pulse out of that many, and never without `pck_en_o`.
- R4: The source field is at bits [1:0]. Code n selects `src_en_i[n]` as the tick that feeds the prescaler.
- R5: A write with `wp_en_i` high leaves `cfg_rd_o`, `ready_o` and `err_o` unchanged.
- R6: A write that changes two or more fields is discarded and sets `err_o`. This holds even when its divider code is reserved. `err_o` then stays high until reset.
- R7: A write that changes one field but carries divider code 5, 6 or 7 is discarded and leaves `err_o` unchanged.
- R8: A write that changes exactly one field is taken at the clock edge where `wr_en_i` is sampled. From the next cycle `cfg_rd_o` shows the new value and `ready_o` is 0.
- R9: A taken change drives the outputs only after the edge that closes a cycle in which `mck_en_o` is high. Until then the old setting stays active. `ready_o` returns to 1 four clock edges after that edge.
- R10: A write while `ready_o` is 0 is discarded and leaves `err_o` unchanged.
- R11: Bits [31:11], 7, 3 and 2 of `cfg_rd_o` read as 0. Data written to them has no effect.
- R12: A write that changes no field leaves `cfg_rd_o` unchanged and `ready_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en_i | input | 4 | Tick enables of the four candidate sources |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Register write data |
| wp_en_i | input | 1 | Write protect; writes are ignored while high |
| cfg_rd_o | output | DATA_W | Register read value |
| ready_o | output | 1 | High when no change is pending or settling |
| err_o | output | 1 | Sticky flag for a rejected multi-field write |
| pck_en_o | output | 1 | Processor clock enable |
| mck_en_o | output | 1 | Master clock enable |

## Verification
Two events can land on the same edge: the taking-over of a pending setting, and the wrap of both counters at the end of a master period. The bench provokes this by writing while long ratios and sparse source ticks are active. The boundary then arrives many cycles after the write. The new ratios must start counting from the very next tick, and the bench checks this against a behavioural model on every clock. A second overlap is a write sent while ready is low, just after a taken change. That write must be ignored, and the pending change must still land unchanged.

// File: rtl/sysclk_div_pkg.sv
package sysclk_div_pkg;

   localparam int SRC_LSB  = 0;
   localparam int PRES_LSB = 4;
   localparam int MDIV_LSB = 8;
   localparam int FIELD_TOP = 10;

   typedef struct packed {
      logic [2:0] mdiv;
      logic [2:0] pres;
      logic [1:0] src;
   } clk_cfg_t;

   localparam clk_cfg_t CFG_RST = '{mdiv: 3'd0, pres: 3'd0, src: 2'd1};

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WAIT   = 2'd1,
      ST_SETTLE = 2'd2
   } seq_st_t;

   function automatic logic [6:0] pres_ratio(input logic [2:0] code);
      logic [6:0] r;
      if (code == 3'd7) r = 7'd3;
      else              r = 7'd1 << code;
      return r;
   endfunction

   function automatic logic [2:0] mdiv_ratio(input logic [2:0] code);
      logic [2:0] r;
      case (code)
         3'd1:    r = 3'd2;
         3'd2:    r = 3'd4;
         3'd3:    r = 3'd3;
         3'd4:    r = 3'd5;
         default: r = 3'd1;
      endcase
      return r;
   endfunction

   function automatic logic mdiv_reserved(input logic [2:0] code);
      return code > 3'd4;
   endfunction

endpackage

// File: rtl/sysclk_ratio_cnt.sv
module sysclk_ratio_cnt #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] ratio_i,
   output logic             pulse_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             last;

   assign last    = (cnt_q == ratio_i - CNT_W'(1));
   assign pulse_o = tick_i && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (last) cnt_q <= '0;
         else      cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/sysclk_cfg_seq.sv
module sysclk_cfg_seq
   import sysclk_div_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int SETTLE_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wp_en_i,
   input  logic              boundary_i,
   output clk_cfg_t          cfg_o,
   output clk_cfg_t          act_o,
   output logic              ready_o,
   output logic              err_o
);

   localparam int SC_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam logic [SC_W-1:0] SC_LAST = SC_W'(SETTLE_CYC - 1);

   clk_cfg_t        cfg_q, act_q, req;
   seq_st_t         st_q;
   logic [SC_W-1:0] sc_q;
   logic            err_q;
   logic [2:0]      diff;
   logic            wr_ok, multi, accept;

   always_comb begin
      req.src  = wr_data_i[SRC_LSB  +: 2];
      req.pres = wr_data_i[PRES_LSB +: 3];
      req.mdiv = wr_data_i[MDIV_LSB +: 3];
      diff     = {req.mdiv != cfg_q.mdiv, req.pres != cfg_q.pres, req.src != cfg_q.src};
      wr_ok    = wr_en_i && !wp_en_i && (st_q == ST_IDLE);
      multi    = wr_ok && ($countones(diff) > 1);
      accept   = wr_ok && ($countones(diff) == 1) && !mdiv_reserved(req.mdiv);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RST;
         act_q <= CFG_RST;
         st_q  <= ST_IDLE;
         sc_q  <= '0;
         err_q <= 1'b0;
      end else begin
         if (multi) err_q <= 1'b1;
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  cfg_q <= req;
                  st_q  <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (boundary_i) begin
                  act_q <= cfg_q;
                  sc_q  <= '0;
                  st_q  <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (sc_q == SC_LAST) st_q <= ST_IDLE;
               else                 sc_q <= sc_q + SC_W'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cfg_o   = cfg_q;
   assign act_o   = act_q;
   assign ready_o = (st_q == ST_IDLE);
   assign err_o   = err_q;

endmodule

// File: rtl/sysclk_div_ctrl.sv
module sysclk_div_ctrl
   import sysclk_div_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int PCNT_W     = 7,
   parameter int MCNT_W     = 3,
   parameter int SETTLE_CYC = 4,
   parameter bit OUT_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        src_en_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wp_en_i,
   output logic [DATA_W-1:0] cfg_rd_o,
   output logic              ready_o,
   output logic              err_o,
   output logic              pck_en_o,
   output logic              mck_en_o
);

   if (DATA_W < FIELD_TOP + 1) begin : g_bad_data_w
      $error("DATA_W too narrow for the field layout");
   end
   if (PCNT_W < 7) begin : g_bad_pcnt_w
      $error("PCNT_W must hold a ratio of 64");
   end
   if (MCNT_W < 3) begin : g_bad_mcnt_w
      $error("MCNT_W must hold a ratio of 5");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end

   clk_cfg_t cfg, act;
   logic     tick, pck, mck;

   sysclk_cfg_seq #(
      .DATA_W     (DATA_W),
      .SETTLE_CYC (SETTLE_CYC)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en_i),
      .wr_data_i  (wr_data_i),
      .wp_en_i    (wp_en_i),
      .boundary_i (mck),
      .cfg_o      (cfg),
      .act_o      (act),
      .ready_o    (ready_o),
      .err_o      (err_o)
   );

   assign tick = src_en_i[act.src];

   sysclk_ratio_cnt #(.CNT_W(PCNT_W)) pres_cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .ratio_i (PCNT_W'(pres_ratio(act.pres))),
      .pulse_o (pck)
   );

   sysclk_ratio_cnt #(.CNT_W(MCNT_W)) mdiv_cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (pck),
      .ratio_i (MCNT_W'(mdiv_ratio(act.mdiv))),
      .pulse_o (mck)
   );

   always_comb begin
      cfg_rd_o = '0;
      cfg_rd_o[SRC_LSB  +: 2] = cfg.src;
      cfg_rd_o[PRES_LSB +: 3] = cfg.pres;
      cfg_rd_o[MDIV_LSB +: 3] = cfg.mdiv;
   end

   if (OUT_REG) begin : g_out_reg
      logic pck_q, mck_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pck_q <= 1'b0;
            mck_q <= 1'b0;
         end else begin
            pck_q <= pck;
            mck_q <= mck;
         end
      end
      assign pck_en_o = pck_q;
      assign mck_en_o = mck_q;
   end else begin : g_out_comb
      assign pck_en_o = pck;
      assign mck_en_o = mck;
   end

endmodule

// File: rtl/sysclk_div_chk.sv
module sysclk_div_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en_i,
   input logic              wp_en_i,
   input logic [DATA_W-1:0] cfg_rd_o,
   input logic              ready_o,
   input logic              err_o,
   input logic              pck_en_o,
   input logic              mck_en_o
);

   // R5
   wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wp_en_i) |=> $stable(cfg_rd_o));

   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !ready_o) |=> $stable(cfg_rd_o));

   // R6
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   // R3
   mck_in_pck_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mck_en_o |-> pck_en_o);

   // R8
   change_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_rd_o) |-> !ready_o);

   // R11
   unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_o[DATA_W-1:11] == '0) && (cfg_rd_o[7] == 1'b0) && (cfg_rd_o[3:2] == 2'b00));

   // R7
   no_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd_o[10:8] <= 3'd4);

endmodule

bind sysclk_div_ctrl sysclk_div_chk #(.DATA_W(DATA_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en_i  (wr_en_i),
   .wp_en_i  (wp_en_i),
   .cfg_rd_o (cfg_rd_o),
   .ready_o  (ready_o),
   .err_o    (err_o),
   .pck_en_o (pck_en_o),
   .mck_en_o (mck_en_o)
);

// File: tb/sysclk_div_ctrl_tb_top.sv
`timescale 1ns/1ps
module sysclk_div_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src_en = 4'b0010;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        wp_en = 1'b0;
   logic [31:0] cfg_rd;
   logic        ready, err, pck_en, mck_en;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   sysclk_div_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_en_i  (src_en),
      .wr_en_i   (wr_en),
      .wr_data_i (wr_data),
      .wp_en_i   (wp_en),
      .cfg_rd_o  (cfg_rd),
      .ready_o   (ready),
      .err_o     (err),
      .pck_en_o  (pck_en),
      .mck_en_o  (mck_en)
   );

   // behavioural reference
   int m_src, m_pres, m_mdiv, a_src, a_pres, a_mdiv;
   int m_st, m_sc, m_err, pc, mc;

   function automatic int p_ratio(int c);
      int t[8] = '{1, 2, 4, 8, 16, 32, 64, 3};
      return t[c];
   endfunction

   function automatic int m_ratio(int c);
      int t[5] = '{1, 2, 4, 3, 5};
      return t[c];
   endfunction

   function automatic bit exp_pck();
      return src_en[a_src] && (pc == p_ratio(a_pres) - 1);
   endfunction

   function automatic bit exp_mck();
      return exp_pck() && (mc == m_ratio(a_mdiv) - 1);
   endfunction

   function automatic int exp_cfg();
      return m_src | (m_pres << 4) | (m_mdiv << 8);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_src = 1; m_pres = 0; m_mdiv = 0;
         a_src = 1; a_pres = 0; a_mdiv = 0;
         m_st = 0; m_sc = 0; m_err = 0; pc = 0; mc = 0;
      end else begin
         bit p, m;
         int old_st, nsrc, npres, nmdiv, nch;
         p = exp_pck();
         m = exp_mck();
         old_st = m_st;
         if (src_en[a_src]) pc = (pc == p_ratio(a_pres) - 1) ? 0 : pc + 1;
         if (p) mc = (mc == m_ratio(a_mdiv) - 1) ? 0 : mc + 1;
         if (old_st == 1 && m) begin
            a_src = m_src; a_pres = m_pres; a_mdiv = m_mdiv;
            m_st = 2; m_sc = 0;
         end else if (old_st == 2) begin
            if (m_sc == 3) m_st = 0;
            else m_sc++;
         end
         if (old_st == 0 && wr_en && !wp_en) begin
            nsrc  = int'(wr_data[1:0]);
            npres = int'(wr_data[6:4]);
            nmdiv = int'(wr_data[10:8]);
            nch = (nsrc != m_src) + (npres != m_pres) + (nmdiv != m_mdiv);
            if (nch > 1) m_err = 1;
            else if (nch == 1 && nmdiv <= 4) begin
               m_src = nsrc; m_pres = npres; m_mdiv = nmdiv; m_st = 1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(cfg_rd == 32'(exp_cfg()), "R8 cfg_rd", int'(cfg_rd), exp_cfg());
         chk(ready == (m_st == 0), "R9 ready", int'(ready), int'(m_st == 0));
         chk(err == m_err[0], "R6 err", int'(err), m_err);
         chk(pck_en == exp_pck(), "R2 pck_en", int'(pck_en), int'(exp_pck()));
         chk(mck_en == exp_mck(), "R3 mck_en", int'(mck_en), int'(exp_mck()));
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // watchdog and cycle count
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         chk(1'b0, "watchdog", cyc, 150000);
         finish_run();
      end
   end

   // source tick patterns
   initial begin
      logic [7:0] lfsr = 8'hA5;
      forever begin
         @(posedge clk); #2;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         src_en[0] = (cyc % 7 == 0);
         src_en[1] = 1'b1;
         src_en[2] = cyc[0];
         src_en[3] = lfsr[0];
      end
   end

   task automatic wr(input logic [31:0] d, input bit wp);
      @(posedge clk); #2;
      wr_en = 1'b1; wr_data = d; wp_en = wp;
      @(posedge clk); #2;
      wr_en = 1'b0; wp_en = 1'b0;
   endtask

   task automatic wait_ready();
      int n = 0;
      @(negedge clk);
      while (!ready && n < 6000) begin
         @(negedge clk);
         n++;
      end
      chk(ready, "R9 ready return", int'(ready), 1);
   endtask

   task automatic step(input logic [31:0] d, input int run);
      wr(d, 1'b0);
      wait_ready();
      repeat (run) @(posedge clk);
   endtask

   initial begin
      int cnt;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(cfg_rd == 32'h1, "R1 reset cfg", int'(cfg_rd), 1);
      chk(ready == 1'b1, "R1 reset ready", int'(ready), 1);
      chk(err == 1'b0, "R1 reset err", int'(err), 0);
      repeat (20) @(posedge clk);

      // R5
      wr(32'h0000_0011, 1'b1);
      @(negedge clk);
      chk(cfg_rd == 32'h1 && ready, "R5 protected write", int'(cfg_rd), 1);

      // R12
      wr(32'h0000_0001, 1'b0);
      @(negedge clk);
      chk(ready == 1'b1, "R12 no-change write ready", int'(ready), 1);

      // R11
      wr(32'hFFFF_F88D & 32'hFFFF_F88D, 1'b0);
      @(negedge clk);
      chk(cfg_rd == 32'h1 && ready, "R11 unused bits", int'(cfg_rd), 1);

      // R6
      wr(32'h0000_0211, 1'b0);
      @(negedge clk);
      chk(cfg_rd == 32'h1 && err, "R6 multi-field", int'({err, cfg_rd[30:0]}), 32'h8000_0001);

      // R7
      wr(32'h0000_0601, 1'b0);
      @(negedge clk);
      chk(cfg_rd == 32'h1 && ready, "R7 reserved divider", int'(cfg_rd), 1);

      // R8
      wr(32'h0000_0021, 1'b0);
      @(negedge clk);
      chk(cfg_rd == 32'h21 && !ready, "R8 accept", int'(cfg_rd), 32'h21);

      // R10
      wr(32'h0000_0001, 1'b0);
      @(negedge clk);
      chk(cfg_rd == 32'h21, "R10 busy write", int'(cfg_rd), 32'h21);
      wait_ready();

      step(32'h0000_0001, 10);
      step(32'h0000_0000, 3);

      // R4
      cnt = 0;
      for (int i = 0; i < 70; i++) begin
         @(negedge clk);
         if (pck_en) cnt++;
      end
      chk(cnt == 10, "R4 slow source ticks", cnt, 10);

      step(32'h0000_0400, 200);
      step(32'h0000_0460, 400);
      step(32'h0000_0462, 300);
      step(32'h0000_0472, 200);
      step(32'h0000_0372, 200);
      step(32'h0000_0373, 300);
      step(32'h0000_0353, 500);
      step(32'h0000_0253, 300);
      step(32'h0000_0153, 200);
      step(32'h0000_0151, 200);
      step(32'h0000_0131, 100);
      step(32'h0000_0130, 500);

      // R6 sticky
      @(negedge clk);
      chk(err == 1'b1, "R6 err still set", int'(err), 1);
      finish_run();
   end

endmodule